// File: doc/BRIEF.md
# Clock Generator Stop-Mode Controller

This block sits beside the clock generator of a small microcontroller. It drives the enables for the crystal oscillator and the PLL, and the gates on the three generator outputs: the crystal clock, the system clock and the clock interrupt. It also holds the system-clock source select. Software writes the select bit, the PLL enable and a configuration bit that keeps the oscillator alive through stop. The core raises stop or wait requests, and a wake-up event brings the device back. The divide-by-two muxing of the two clock sources is represented only by the select bit and the gate enables.

When stop is accepted, the PLL is always switched off and a PLL source selection is dropped on the same edge, so the device always resumes on the crystal clock. With the keep-alive bit clear, the oscillator and every output gate also go off. A wake-up event then restarts the oscillator and waits a parameterised number of crystal cycles before it releases the system clock. With keep-alive set, the oscillator never stopped, so wake-up returns to run at once. Wait mode leaves all clocks running, and software can still move the source away from the PLL while keeping the PLL enabled.

Top module: `clkgen_stop_ctrl`

## Requirements
- R1: After a synchronous active-high reset, keepOsc=0, srcSelPll=0, pllEn=1, oscEn=1, all three gates are 1 and mode=0 (run). Reset also applies in the middle of stop.
- R2: A stop request accepted in run with keepOsc=0 gives, from the next cycle and for all of stop (mode=2), oscEn=0, pllEn=0, xclkGateEn=0, sysClkGateEn=0 and intGateEn=0.
- R3: The edge that accepts a stop request clears srcSelPll and pllEn.
- R4: After a stop, srcSelPll stays 0 until software re-enables the PLL and then writes the select bit to 1.
- R5: With keepOsc=1, stop turns pllEn, sysClkGateEn and intGateEn off, and keeps oscEn=1 and xclkGateEn=1.
- R6: A wake-up event in stop with keepOsc=0 sets oscEn=1 on the next edge and enters mode=3 (stabilise). sysClkGateEn stays 0 for STAB_CYCLES cycles, and mode then returns to 0 with all gates on.
- R7: A wake-up event in stop with keepOsc=1 returns to mode=0 on the next edge with no stabilisation wait.
- R8: A wait request in run gives mode=1 and changes no enable or gate. In wait, software may change srcSelPll while pllEn stays 1. A wake-up event returns to mode=0.
- R9: A write of 1 to the select bit is ignored while pllEn=0. Writes of 0 are always accepted.
- R10: Stop has priority over a simultaneous wait request. A wake-up event in run has no effect.
- R11: Writes of the configuration bit, the select bit and the PLL enable are ignored in stop and in stabilise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Write strobe for the keep-alive configuration bit |
| cfgWrData | input | 1 | Keep-alive value to write |
| selWrEn | input | 1 | Write strobe for the source select |
| selWrData | input | 1 | Source select value to write, 1 = PLL |
| pllWrEn | input | 1 | Write strobe for the PLL enable |
| pllWrData | input | 1 | PLL enable value to write |
| stopReq | input | 1 | Stop request from the core |
| waitReq | input | 1 | Wait request from the core |
| wakeEvt | input | 1 | Wake-up event |
| mode | output | 2 | 0 run, 1 wait, 2 stop, 3 stabilise |
| oscEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL enable |
| xclkGateEn | output | 1 | Crystal-clock output gate |
| sysClkGateEn | output | 1 | System-clock output gate |
| intGateEn | output | 1 | Clock-interrupt output gate |
| srcSelPll | output | 1 | Effective source select, readable by software |
| keepOsc | output | 1 | Keep-alive configuration bit readback |

## Verification
The hardest state to reach from the ports is the edge that accepts a stop while the PLL is selected and software writes land in the same cycle or during stop. On that edge the select clear has to win over every write, and the later writes have to leave no trace. The stimulus sets the select bit to PLL first, then raises stop together with wait. It issues writes during stop, wakes the block and tries to set the select bit again before re-enabling the PLL. The stabilise window is then counted sample by sample up to the release of the system clock.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_STAB = 2'd3
  } modeT;

  typedef struct packed {
    modeT mode;
    logic enterStop;
    logic swOk;
  } ctrlStrobeT;

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stopReq,
  input  logic       waitReq,
  input  logic       wakeEvt,
  input  logic       keepOsc,
  output ctrlStrobeT strobe
);

  localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  modeT modeQ, modeD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic enterStop;

  always_comb begin
    modeD     = modeQ;
    cntD      = cntQ;
    enterStop = 1'b0;
    unique case (modeQ)
      MODE_RUN: begin
        if (stopReq) begin
          modeD     = MODE_STOP;
          enterStop = 1'b1;
        end else if (waitReq) begin
          modeD = MODE_WAIT;
        end
      end
      MODE_WAIT: begin
        if (wakeEvt) modeD = MODE_RUN;
      end
      MODE_STOP: begin
        if (wakeEvt) begin
          if (keepOsc) begin
            modeD = MODE_RUN;
          end else begin
            modeD = MODE_STAB;
            cntD  = '0;
          end
        end
      end
      MODE_STAB: begin
        if (cntQ == CNT_LAST) modeD = MODE_RUN;
        else cntD = cntQ + 1'b1;
      end
      default: modeD = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_RUN;
      cntQ  <= '0;
    end else begin
      modeQ <= modeD;
      cntQ  <= cntD;
    end
  end

  always_comb begin
    strobe.mode      = modeQ;
    strobe.enterStop = enterStop;
    strobe.swOk      = (modeQ == MODE_RUN) || (modeQ == MODE_WAIT);
  end

endmodule

// File: rtl/clkstop_dp.sv
module clkstop_dp
  import clkstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrlStrobeT strobe,
  input  logic       cfgWrEn,
  input  logic       cfgWrData,
  input  logic       selWrEn,
  input  logic       selWrData,
  input  logic       pllWrEn,
  input  logic       pllWrData,
  output logic       oscEn,
  output logic       pllEn,
  output logic       xclkGateEn,
  output logic       sysClkGateEn,
  output logic       intGateEn,
  output logic       srcSelPll,
  output logic       keepOsc
);

  logic keepQ, selQ, pllQ;
  logic clocksUp, inStop;

  always_ff @(posedge clk) begin
    if (rst) begin
      keepQ <= 1'b0;
      selQ  <= 1'b0;
      pllQ  <= 1'b1;
    end else if (strobe.enterStop) begin
      selQ <= 1'b0;
      pllQ <= 1'b0;
    end else if (strobe.swOk) begin
      if (cfgWrEn) keepQ <= cfgWrData;
      if (pllWrEn) pllQ <= pllWrData;
      if (selWrEn && (!selWrData || pllQ)) selQ <= selWrData;
    end
  end

  always_comb begin
    clocksUp     = (strobe.mode == MODE_RUN) || (strobe.mode == MODE_WAIT);
    inStop       = (strobe.mode == MODE_STOP);
    oscEn        = !(inStop && !keepQ);
    pllEn        = pllQ;
    xclkGateEn   = clocksUp || (inStop && keepQ);
    sysClkGateEn = clocksUp;
    intGateEn    = clocksUp;
    srcSelPll    = selQ;
    keepOsc      = keepQ;
  end

endmodule

// File: rtl/clkgen_stop_ctrl.sv
module clkgen_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWrEn,
  input  logic       cfgWrData,
  input  logic       selWrEn,
  input  logic       selWrData,
  input  logic       pllWrEn,
  input  logic       pllWrData,
  input  logic       stopReq,
  input  logic       waitReq,
  input  logic       wakeEvt,
  output logic [1:0] mode,
  output logic       oscEn,
  output logic       pllEn,
  output logic       xclkGateEn,
  output logic       sysClkGateEn,
  output logic       intGateEn,
  output logic       srcSelPll,
  output logic       keepOsc
);

  ctrlStrobeT strobe;

  clkstop_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stopReq (stopReq),
    .waitReq (waitReq),
    .wakeEvt (wakeEvt),
    .keepOsc (keepOsc),
    .strobe  (strobe)
  );

  clkstop_dp u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .selWrEn      (selWrEn),
    .selWrData    (selWrData),
    .pllWrEn      (pllWrEn),
    .pllWrData    (pllWrData),
    .oscEn        (oscEn),
    .pllEn        (pllEn),
    .xclkGateEn   (xclkGateEn),
    .sysClkGateEn (sysClkGateEn),
    .intGateEn    (intGateEn),
    .srcSelPll    (srcSelPll),
    .keepOsc      (keepOsc)
  );

  assign mode = strobe.mode;

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk (
  input logic       clk,
  input logic       rst,
  input logic       pllWrEn,
  input logic       pllWrData,
  input logic       stopReq,
  input logic       waitReq,
  input logic [1:0] mode,
  input logic       oscEn,
  input logic       pllEn,
  input logic       xclkGateEn,
  input logic       sysClkGateEn,
  input logic       intGateEn,
  input logic       srcSelPll,
  input logic       keepOsc
);

  AST_STOP_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !keepOsc) |-> (!oscEn && !pllEn && !xclkGateEn && !sysClkGateEn && !intGateEn)); // R2

  AST_STOP_CLEARS_SEL: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && stopReq) |=> (!srcSelPll && !pllEn && mode == 2'd2)); // R3

  AST_KEEP_OSC_RUNS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && keepOsc) |-> (oscEn && xclkGateEn && !pllEn && !sysClkGateEn)); // R5

  AST_STAB_SYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |-> (oscEn && !sysClkGateEn && !xclkGateEn)); // R6

  AST_WAIT_KEEPS_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && waitReq && !stopReq) |=> (mode == 2'd1 && sysClkGateEn && $stable(pllEn))); // R8

  AST_SEL_NEEDS_PLL: assert property (@(posedge clk) disable iff (rst)
    (!pllEn && !srcSelPll) |=> !srcSelPll); // R9

endmodule

bind clkgen_stop_ctrl clkstop_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pllWrEn      (pllWrEn),
  .pllWrData    (pllWrData),
  .stopReq      (stopReq),
  .waitReq      (waitReq),
  .mode         (mode),
  .oscEn        (oscEn),
  .pllEn        (pllEn),
  .xclkGateEn   (xclkGateEn),
  .sysClkGateEn (sysClkGateEn),
  .intGateEn    (intGateEn),
  .srcSelPll    (srcSelPll),
  .keepOsc      (keepOsc)
);

// File: tb/sim_clkgen_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clkgen_stop_ctrl;

  localparam int STAB = 16;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrEn = 0, cfgWrData = 0, selWrEn = 0, selWrData = 0;
  logic pllWrEn = 0, pllWrData = 0, stopReq = 0, waitReq = 0, wakeEvt = 0;
  logic [1:0] mode;
  logic oscEn, pllEn, xclkGateEn, sysClkGateEn, intGateEn, srcSelPll, keepOsc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkgen_stop_ctrl #(.STAB_CYCLES(STAB)) u0 (
    .clk(clk), .rst(rst),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .pllWrEn(pllWrEn), .pllWrData(pllWrData),
    .stopReq(stopReq), .waitReq(waitReq), .wakeEvt(wakeEvt),
    .mode(mode), .oscEn(oscEn), .pllEn(pllEn), .xclkGateEn(xclkGateEn),
    .sysClkGateEn(sysClkGateEn), .intGateEn(intGateEn),
    .srcSelPll(srcSelPll), .keepOsc(keepOsc)
  );

  // {req, inputs stop,wait,wake,selEn,selD,pllEn,pllD,cfgEn,cfgD,
  //  expected mode[1:0],osc,pll,xclk,sys,int,sel,keep}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd1,  9'b000000000, 9'b00_11111_00}, // R1 idle after reset
    {4'd9,  9'b000110000, 9'b00_11111_10}, // R9 set select, PLL on
    {4'd8,  9'b010000000, 9'b01_11111_10}, // R8 enter wait
    {4'd8,  9'b000100000, 9'b01_11111_00}, // R8 deselect PLL in wait
    {4'd8,  9'b000110000, 9'b01_11111_10}, // R8 reselect in wait
    {4'd8,  9'b001000000, 9'b00_11111_10}, // R8 wake from wait
    {4'd9,  9'b000100000, 9'b00_11111_00}, // R9 clear select
    {4'd9,  9'b000001000, 9'b00_10111_00}, // R9 PLL off
    {4'd9,  9'b000110000, 9'b00_10111_00}, // R9 set ignored, PLL off
    {4'd9,  9'b000001100, 9'b00_11111_00}, // R9 PLL on
    {4'd9,  9'b000110000, 9'b00_11111_10}, // R9 set accepted
    {4'd5,  9'b000000011, 9'b00_11111_11}, // R5 keep-alive on
    {4'd10, 9'b110000000, 9'b10_10100_01}, // R10 R3 R5 stop beats wait
    {4'd11, 9'b000000010, 9'b10_10100_01}, // R11 cfg write in stop ignored
    {4'd7,  9'b001000000, 9'b00_10111_01}, // R7 direct wake
    {4'd4,  9'b000110000, 9'b00_10111_01}, // R4 select stays clear
    {4'd10, 9'b001000000, 9'b00_10111_01}, // R10 wake in run ignored
    {4'd4,  9'b000001100, 9'b00_11111_01}, // R4 PLL re-enabled
    {4'd4,  9'b000110000, 9'b00_11111_11}  // R4 select set again
  };

  function automatic logic [8:0] outs();
    return {mode, oscEn, pllEn, xclkGateEn, sysClkGateEn, intGateEn, srcSelPll, keepOsc};
  endfunction

  task automatic drive(input logic [8:0] v);
    {stopReq, waitReq, wakeEvt, selWrEn, selWrData, pllWrEn, pllWrData, cfgWrEn, cfgWrData} = v;
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", outs(), 9'b00_11111_00);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][17:9]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][21:18], i), outs(), VEC[i][8:0]);
    end

    // keep-alive off, select PLL, then stop: R2 and R3
    drive(9'b000000010);
    @(negedge clk);
    drive(9'b100000000);
    @(negedge clk);
    check("R2 R3 stop entry", outs(), 9'b10_00000_00);
    drive(9'b000111100); // R11 writes during stop
    @(negedge clk);
    check("R11 writes in stop", outs(), 9'b10_00000_00);

    // R6 wake and stabilise window
    drive(9'b001000000);
    for (int k = 0; k <= STAB; k++) begin
      @(negedge clk);
      drive(9'b000000000);
      if (k < STAB) check("R6 stabilise", outs(), 9'b11_10000_00);
      else check("R6 released", outs(), 9'b00_10111_00);
    end
    check("R4 select clear after wake", {8'd0, srcSelPll}, 9'd0);

    // R1 reset in the middle of stop
    drive(9'b100000000);
    @(negedge clk);
    drive(9'b000000000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset during stop", outs(), 9'b00_11111_00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule